// File: doc/BRIEF.md
# Supply-Monitor Reset Filter

This block is the digital back end of a supply-voltage monitor. Two comparator outputs feed it, both already synchronous to the CPU clock. One reports that the supply is at or below the falling trip level. The other reports that the supply is above the separate, higher rising trip level. The block filters these over CPU clock cycles. A reset request is raised only after the low indication has persisted without a break for a set number of cycles (nine by default). Once raised, the request holds until the rising comparator reports the supply above its level for a single cycle. The two thresholds give hysteresis, and the filtering is asymmetric: slow to trip, quick to release.

Three configuration bits gate the block: a monitor enable, a reset enable and a stop-mode enable. The configuration register that holds them resets them to the active state, so monitoring is on coming out of reset. The block drives a registered reset request, a registered active-low reset pin drive and a readable status flag that follows the falling comparator. An optional synchronizer chain of parameter depth can be placed on the comparator inputs. Its default depth is zero, for inputs that are already synchronous.

Top module: `lvr_filter_top`

## Requirements
- R1: With the monitor active and the reset enable set, `lv_reset_o` goes to 1 on the clock edge that samples `below_fall_i`=1 for the ninth consecutive time. A run of eight samples followed by a 0 does not set it.
- R2: A single sample of `below_fall_i`=0 inside a run restarts the count, so the reset needs nine further consecutive samples at 1.
- R3: Once set, `lv_reset_o` stays 1 while `above_rise_i` is 0, even after `below_fall_i` has returned to 0.
- R4: `lv_reset_o` clears on the first edge that samples `above_rise_i`=1 while it is set.
- R5: While `rst_en_i` is 0, neither reset output asserts and `status_o` still follows `below_fall_i`.
- R6: While `mon_en_i` is 0, the filter count is cleared, the reset outputs are inactive (`lv_reset_o`=0, `ext_rst_n_o`=1) and `status_o` reads 0. When monitoring resumes, nine fresh low samples are needed.
- R7: With `stop_mode_i`=1 and `stop_en_i`=0, the block behaves as if disabled (as in R6). With `stop_en_i`=1, monitoring continues in stop mode.
- R8: The filter count saturates and does not wrap. After 20 low samples with `rst_en_i`=0, setting `rst_en_i`=1 while `below_fall_i` is still 1 sets `lv_reset_o` on the next edge.
- R9: `ext_rst_n_o` is always the inverse of `lv_reset_o`. After reset, `lv_reset_o`=0, `ext_rst_n_o`=1 and `status_o`=0.
- R10: `status_o` is 1 one edge after `below_fall_i` is sampled 1 with the monitor active, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| below_fall_i | input | 1 | Supply at or below the falling trip level |
| above_rise_i | input | 1 | Supply above the rising trip level |
| mon_en_i | input | 1 | Monitor power enable |
| rst_en_i | input | 1 | Reset generation enable |
| stop_en_i | input | 1 | Keep monitoring during stop mode |
| stop_mode_i | input | 1 | Device is in stop mode |
| lv_reset_o | output | 1 | Registered low-voltage reset request |
| ext_rst_n_o | output | 1 | Registered active-low external reset drive |
| status_o | output | 1 | Registered status flag following the falling comparator |

## Verification
The filter is driven with runs of low samples of length eight, nine and more than twenty, and with a run broken by a single high sample. These separate a correct nine-cycle threshold from off-by-one and non-restarting counters. Release is tried with the low indication removed while the rising comparator stays 0, then with a rising indication lasting one cycle, which shows that the hold depends on the rising input alone. Each gating bit is toggled against an ongoing low run. Re-enabling the reset after a long run shows whether the count saturated or wrapped.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
  parameter int unsigned LVR_TRIP_DEFAULT = 9;

  typedef struct packed {
    logic below;
    logic above;
  } lvr_cmp_t;
endpackage

// File: rtl/lvr_filt_cnt.sv
module lvr_filt_cnt #(
  parameter int unsigned TRIP_CYCLES = lvr_pkg::LVR_TRIP_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic near_trip_o
);
  localparam int unsigned CW = $clog2(TRIP_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(TRIP_CYCLES);
  localparam logic [CW-1:0] CNT_NEAR = CW'(TRIP_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i)                cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // the current low sample is at least the TRIP_CYCLES-th in a row
  assign near_trip_o = (cnt_q >= CNT_NEAR);

  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/lvr_hold.sv
module lvr_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic rst_en_i,
  input  logic below_i,
  input  logic above_i,
  input  logic near_trip_i,
  output logic lv_o,
  output logic ext_n_o
);
  logic lv_q, lv_d, ext_n_q;

  always_comb begin
    if (!active_i || !rst_en_i) lv_d = 1'b0;
    else if (lv_q)              lv_d = !above_i;
    else                        lv_d = below_i && near_trip_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_q    <= 1'b0;
      ext_n_q <= 1'b1;
    end else begin
      lv_q    <= lv_d;
      ext_n_q <= !lv_d;
    end
  end

  assign lv_o    = lv_q;
  assign ext_n_o = ext_n_q;

  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_en_i |=> !lv_q);
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_q && above_i) |=> !lv_q);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_q && !above_i && active_i && rst_en_i) |=> lv_q);
  p_no_trip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!lv_q && !below_i) |=> !lv_q);
  p_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_n_q == !lv_q);
endmodule

// File: rtl/lvr_filter_top.sv
module lvr_filter_top #(
  parameter int unsigned TRIP_CYCLES = lvr_pkg::LVR_TRIP_DEFAULT,
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_fall_i,
  input  logic above_rise_i,
  input  logic mon_en_i,
  input  logic rst_en_i,
  input  logic stop_en_i,
  input  logic stop_mode_i,
  output logic lv_reset_o,
  output logic ext_rst_n_o,
  output logic status_o
);
  import lvr_pkg::*;

  lvr_cmp_t cmp_raw, cmp;
  logic     active, status_q, status_d, near_trip, cnt_clr;

  assign cmp_raw.below = below_fall_i;
  assign cmp_raw.above = above_rise_i;

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      lvr_cmp_t sync_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
        end else begin
          sync_q[0] <= cmp_raw;
          for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
      end
      assign cmp = sync_q[SYNC_STAGES-1];
    end else begin : g_nosync
      assign cmp = cmp_raw;
    end
  endgenerate

  assign active   = mon_en_i && (!stop_mode_i || stop_en_i);
  assign cnt_clr  = !active || !cmp.below;
  assign status_d = active && cmp.below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= status_d;
  end
  assign status_o = status_q;

  lvr_filt_cnt #(.TRIP_CYCLES(TRIP_CYCLES)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (cnt_clr),
    .near_trip_o (near_trip)
  );

  lvr_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active),
    .rst_en_i    (rst_en_i),
    .below_i     (cmp.below),
    .above_i     (cmp.above),
    .near_trip_i (near_trip),
    .lv_o        (lv_reset_o),
    .ext_n_o     (ext_rst_n_o)
  );

  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en_i |=> (!status_o && !lv_reset_o && ext_rst_n_o));
  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode_i && !stop_en_i) |=> (!status_o && !lv_reset_o));
  p_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp.below |=> !status_o);
endmodule

// File: tb/tb_lvr_filter_top.sv
module tb_lvr_filter_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bf = 1'b0, ar = 1'b1, en = 1'b1, ren = 1'b1, sen = 1'b1, stp = 1'b0;
  logic lv, extn, st;

  always #10 clk = ~clk;

  lvr_filter_top dut (
    .clk(clk), .rst_n(rst_n), .below_fall_i(bf), .above_rise_i(ar),
    .mon_en_i(en), .rst_en_i(ren), .stop_en_i(sen), .stop_mode_i(stp),
    .lv_reset_o(lv), .ext_rst_n_o(extn), .status_o(st)
  );

  typedef struct {
    logic  lv;
    logic  st;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   vectors = 0, errors = 0;
  int   mcnt = 0;
  logic mlv = 1'b0;
  bit   running = 1'b0;

  task automatic chk(input string tag, input logic a, input logic e, input string what);
    vectors++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, a, e);
    end
  endtask

  task automatic step(input logic b, input logic a, input logic e, input logic r,
                      input logic s, input logic sm, input string tag);
    exp_t x;
    logic act;
    @(negedge clk);
    bf = b; ar = a; en = e; ren = r; sen = s; stp = sm;
    act = e && (!sm || s);
    if (!act || !b) mcnt = 0;
    else if (mcnt < 9) mcnt++;
    if (!act || !r) mlv = 1'b0;
    else if (mlv)   mlv = !a;
    else            mlv = b && (mcnt >= 9);
    x.lv = mlv; x.st = act && b; x.tag = tag;
    exp_q.push_back(x);
  endtask

  task automatic run(input int n, input logic b, input logic a, input logic e,
                     input logic r, input logic s, input logic sm, input string tag);
    for (int i = 0; i < n; i++) step(b, a, e, r, s, sm, tag);
  endtask

  always @(posedge clk) begin
    if (running) begin
      #2;
      if (exp_q.size() > 0) begin
        exp_t x;
        x = exp_q.pop_front();
        chk(x.tag, lv, x.lv, "lv_reset_o");
        chk(x.tag, st, x.st, "status_o");
        chk("R9", extn, !lv, "ext_rst_n_o");
      end
    end
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #35;
    chk("R9", lv, 1'b0, "reset lv_reset_o");
    chk("R9", extn, 1'b1, "reset ext_rst_n_o");
    chk("R9", st, 1'b0, "reset status_o");
    @(negedge clk); rst_n = 1'b1;
    running = 1'b1;
    run(3, 0, 1, 1, 1, 1, 0, "R10");
    // R1: eight lows do not trip, nine do
    run(8, 1, 0, 1, 1, 1, 0, "R1");
    run(1, 0, 0, 1, 1, 1, 0, "R1");
    run(9, 1, 0, 1, 1, 1, 0, "R1");
    run(3, 1, 0, 1, 1, 1, 0, "R8");
    // R3: hold with low gone but no rising indication
    run(5, 0, 0, 1, 1, 1, 0, "R3");
    // R4: one rising cycle releases
    run(1, 0, 1, 1, 1, 1, 0, "R4");
    run(2, 0, 1, 1, 1, 1, 0, "R4");
    // R2: a single gap restarts the run
    run(5, 1, 0, 1, 1, 1, 0, "R2");
    run(1, 0, 0, 1, 1, 1, 0, "R2");
    run(9, 1, 0, 1, 1, 1, 0, "R2");
    run(1, 0, 1, 1, 1, 1, 0, "R4");
    // R5: reset disabled, status still follows
    run(12, 1, 0, 1, 0, 1, 0, "R5");
    // R8: saturation, re-enable trips at once
    run(10, 1, 0, 1, 0, 1, 0, "R8");
    run(2, 1, 0, 1, 1, 1, 0, "R8");
    // R6: monitor disable drops reset and status
    run(12, 1, 0, 0, 1, 1, 0, "R6");
    run(9, 1, 0, 1, 1, 1, 0, "R6");
    run(1, 0, 1, 1, 1, 1, 0, "R4");
    // R7: stop mode with and without stop enable
    run(12, 1, 0, 1, 1, 0, 1, "R7");
    run(10, 1, 0, 1, 1, 1, 1, "R7");
    run(1, 0, 1, 1, 1, 1, 1, "R7");
    run(4, 0, 1, 1, 1, 1, 0, "R10");
    @(negedge clk);
    @(negedge clk);
    running = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule